// File: doc/BRIEF.md
# Codirectional 64 kbit/s Receiver with Octet Alignment and PCM Burst Output

This block receives a 64 kbit/s codirectional line signal that a line receiver has already turned into two active-low rails, one per polarity. Every data bit is carried by a block of four unit intervals. The block is clocked by a recovered clock that gives two edges per bit. The first edge of a bit samples the block polarity and the second edge samples the data unit interval. A block whose polarity repeats the polarity of the block before it is a violation, and a violation marks the last bit of an octet. The line-side state machine starts in `LN_HUNT`. It moves to `LN_LOCK` on the first violation (transition HUNT→LOCK) and stays locked after that. While locked it keeps its octet phase across missing violations, and it realigns when a violation arrives at an unexpected bit position.

Each completed octet is written into one of two ping-pong registers, together with a flag that records whether its violation was missing. Writing toggles a ready bit, which is brought into the local 2.048 MHz PCM domain through a two-flop synchronizer. The PCM-side state machine (`RD_IDLE`, `RD_SHIFT`, `RD_GAP`) loads the newest octet when the selected time-slot opens (transition IDLE→SHIFT). It then shifts the octet out LSB-first, one bit per rising edge, moves to `RD_GAP` after eight bits (SHIFT→GAP), and returns to idle once the slot closes (GAP→IDLE). When no new octet has arrived since the previous burst, the previous octet is replayed and the repeat flag is raised. When two or more octets have arrived, only the newest is sent and the drop flag is raised. Two inputs can force the output to all ones, and an alarm reports a run of missing violations.

Top module: `codir_rx`

## Requirements
- R1: During and right after reset, `pcm_out` is 1 and `slip_repeat`, `slip_drop` and `octet_alarm` are 0. The held replay word resets to 8'hFF.
- R2: The rails are active low (0 = mark). At the first edge of each bit, `line_p_n`=0 gives positive polarity and otherwise the polarity is negative. At the second edge, a mark on either rail decodes as 1 (block 1100) and a space decodes as 0 (block 1010).
- R3: A block with the same polarity as the previous block is a violation that ends an octet. The first bit received of an octet is the first bit out (`pcm_out` bit 0). Before the first violation after reset (HUNT state), no octet is stored.
- R4: A burst drives bit k of the octet on `pcm_out` after the (k+1)-th rising edge of `clk_pcm` at which the selected slot is high, for k = 0..7. Outside bursts, `pcm_out` is 1.
- R5: `slot_pick`=1 selects `slot_a` and `slot_pick`=0 selects `slot_b`. The unselected slot has no effect on `pcm_out` and does not consume a pending octet.
- R6: When the violation at the expected last-bit position is missing, the octet phase is kept and the octet is stored and delivered correctly while `miss_blank_n` is 1.
- R7: With `miss_blank_n`=0, a burst of an octet whose violation was missing is all ones.
- R8: `force_ones`=1 makes `pcm_out` 1 on every following edge, so a burst under it reads 8'hFF.
- R9: `octet_alarm` rises when the 8th successive expected violation is missing, and not after the 7th.
- R10: `octet_alarm` clears on the first violation received at the expected position.
- R11: If no new octet has been completed since the previous burst, the burst replays the previous octet and `slip_repeat` is 1 from the first burst edge until the next burst load.
- R12: If two or more octets have been completed since the previous burst, only the newest is sent and `slip_drop` is 1 for that burst. `slip_repeat` and `slip_drop` are never 1 together.
- R13: A violation at any position other than the last bit realigns the octet phase. The partial octet is discarded, and the next octet ends at the 8th bit after the realignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pcm | input | 1 | Local 2.048 MHz PCM clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rclk | input | 1 | Recovered line clock, two rising edges per bit |
| line_p_n | input | 1 | Positive-polarity rail, active low |
| line_m_n | input | 1 | Negative-polarity rail, active low |
| slot_a | input | 1 | Time-slot envelope A |
| slot_b | input | 1 | Time-slot envelope B |
| slot_pick | input | 1 | 1 selects slot_a, 0 selects slot_b |
| miss_blank_n | input | 1 | Active low: blank octets whose violation was missing |
| force_ones | input | 1 | Forces pcm_out to all ones |
| pcm_out | output | 1 | Serial PCM burst output, registered |
| slip_repeat | output | 1 | Current burst is a replayed octet |
| slip_drop | output | 1 | An octet was dropped before the current burst |
| octet_alarm | output | 1 | Eight successive missing violations |

## Verification
Bit k of a burst is due after the (k+1)-th rising PCM edge inside the slot, and both slip flags are valid after the first of those edges. The bench therefore samples every burst bit and the flags at the falling edge that follows the corresponding rising edge, and it checks for an idle 1 one edge after the burst. A completed octet reaches the PCM side about three PCM cycles after the recovered-clock edge that samples its last data interval, so the bench waits ten PCM cycles before it opens a slot. The alarm changes on that same recovered-clock edge, and the bench reads it once the octet has been sent. Expected words, flags and blanking come from a bench model of pending octets; a monitor pops and compares them as each burst appears.

// File: rtl/codir_pkg.sv
package codir_pkg;
    typedef enum logic [0:0] {LN_HUNT, LN_LOCK} ln_state_t;
    typedef enum logic [1:0] {RD_IDLE, RD_SHIFT, RD_GAP} rd_state_t;
endpackage

// File: rtl/codir_line_rx.sv
module codir_line_rx
    import codir_pkg::*;
#(
    parameter int OCT_W    = 8,
    parameter int MISS_LIM = 8
) (
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             line_p_n,
    input  logic             line_m_n,
    output logic [OCT_W:0]   bank0,
    output logic [OCT_W:0]   bank1,
    output logic             wr_tog,
    output logic             alarm
);
    localparam int CW = $clog2(OCT_W);
    localparam int MW = $clog2(MISS_LIM + 1);

    ln_state_t        st, st_nx;
    logic             half, pol_prev, have_prev, viol_r;
    logic [CW-1:0]    bidx;
    logic [OCT_W-1:0] sh, sh_nx;
    logic [MW-1:0]    miss_cnt;
    logic [OCT_W:0]   bank [2];
    logic             bit_v, last_pos, wr_en, wr_miss, realign;

    assign bit_v    = ~line_p_n | ~line_m_n;
    assign last_pos = (bidx == CW'(OCT_W - 1));
    assign sh_nx    = {bit_v, sh[OCT_W-1:1]};
    assign bank0    = bank[0];
    assign bank1    = bank[1];

    always_comb begin
        st_nx   = st;
        wr_en   = 1'b0;
        wr_miss = 1'b0;
        realign = 1'b0;
        if (half) begin
            unique case (st)
                LN_HUNT: begin
                    if (viol_r) begin
                        st_nx   = LN_LOCK;
                        realign = 1'b1;
                    end
                end
                LN_LOCK: begin
                    if (viol_r && !last_pos) begin
                        realign = 1'b1;
                    end else if (last_pos) begin
                        wr_en   = 1'b1;
                        wr_miss = ~viol_r;
                    end
                end
                default: st_nx = LN_HUNT;
            endcase
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) st <= LN_HUNT;
        else        st <= st_nx;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            half      <= 1'b0;
            pol_prev  <= 1'b0;
            have_prev <= 1'b0;
            viol_r    <= 1'b0;
            bidx      <= '0;
            sh        <= '1;
            miss_cnt  <= '0;
            alarm     <= 1'b0;
            wr_tog    <= 1'b0;
            bank[0]   <= {1'b0, {OCT_W{1'b1}}};
            bank[1]   <= {1'b0, {OCT_W{1'b1}}};
        end else begin
            half <= ~half;
            if (!half) begin
                viol_r    <= have_prev && (~line_p_n == pol_prev);
                pol_prev  <= ~line_p_n;
                have_prev <= 1'b1;
            end else begin
                sh <= sh_nx;
                if (realign || last_pos) bidx <= '0;
                else                     bidx <= bidx + 1'b1;
                if (wr_en) begin
                    bank[wr_tog] <= {wr_miss, sh_nx};
                    wr_tog       <= ~wr_tog;
                end
                if (st == LN_LOCK && last_pos) begin
                    if (viol_r) begin
                        miss_cnt <= '0;
                        alarm    <= 1'b0;
                    end else begin
                        if (miss_cnt != MW'(MISS_LIM)) miss_cnt <= miss_cnt + 1'b1;
                        if (miss_cnt == MW'(MISS_LIM - 1)) alarm <= 1'b1;
                    end
                end
            end
        end
    end

    // R9
    alarm_set_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $rose(alarm) |-> ($past(miss_cnt) == MW'(MISS_LIM - 1)));
    // R10
    alarm_clr_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $fell(alarm) |-> $past(viol_r && last_pos && half));
    // R3
    hunt_no_store_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (st == LN_HUNT) |=> $stable(wr_tog));
endmodule

// File: rtl/codir_tog_sync.sv
module codir_tog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= {r[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = r[STAGES-1];
endmodule

// File: rtl/codir_pcm_tx.sv
module codir_pcm_tx
    import codir_pkg::*;
#(
    parameter int OCT_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slot,
    input  logic           force_ones,
    input  logic           miss_blank_n,
    input  logic           tog_s,
    input  logic [OCT_W:0] bank0,
    input  logic [OCT_W:0] bank1,
    output logic           pcm_q,
    output logic           rep_q,
    output logic           del_q
);
    localparam int CW = $clog2(OCT_W + 1);

    rd_state_t        st, st_nx;
    logic             tog_d, tog_edge, miss_q;
    logic [1:0]       new_cnt;
    logic [OCT_W:0]   hold, latest, word;
    logic [OCT_W-1:0] sh;
    logic [CW-1:0]    cnt;

    assign tog_edge = tog_s ^ tog_d;
    assign latest   = tog_d ? bank0 : bank1;
    assign word     = (new_cnt == 2'd0) ? hold : latest;

    always_comb begin
        st_nx = st;
        unique case (st)
            RD_IDLE:  if (slot) st_nx = RD_SHIFT;
            RD_SHIFT: if (cnt == CW'(OCT_W)) st_nx = RD_GAP;
            RD_GAP:   if (!slot) st_nx = RD_IDLE;
            default:  st_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RD_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_d   <= 1'b0;
            new_cnt <= 2'd0;
            hold    <= {1'b0, {OCT_W{1'b1}}};
            sh      <= '1;
            cnt     <= '0;
            miss_q  <= 1'b0;
            pcm_q   <= 1'b1;
            rep_q   <= 1'b0;
            del_q   <= 1'b0;
        end else begin
            tog_d <= tog_s;
            if (st == RD_IDLE && slot) begin
                hold    <= word;
                miss_q  <= word[OCT_W];
                sh      <= {1'b1, word[OCT_W-1:1]};
                pcm_q   <= (force_ones | (~miss_blank_n & word[OCT_W])) | word[0];
                rep_q   <= (new_cnt == 2'd0);
                del_q   <= (new_cnt == 2'd2);
                new_cnt <= tog_edge ? 2'd1 : 2'd0;
                cnt     <= CW'(1);
            end else begin
                if (tog_edge && new_cnt != 2'd2) new_cnt <= new_cnt + 2'd1;
                if (st == RD_SHIFT && cnt != CW'(OCT_W)) begin
                    pcm_q <= (force_ones | (~miss_blank_n & miss_q)) | sh[0];
                    sh    <= {1'b1, sh[OCT_W-1:1]};
                    cnt   <= cnt + 1'b1;
                end else begin
                    pcm_q <= 1'b1;
                end
            end
        end
    end

    // R12
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rep_q, del_q}));
    // R4
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RD_IDLE) |-> pcm_q);
    // R8
    force_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_ones |=> pcm_q);
    // R4
    shift_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RD_SHIFT) |-> (cnt >= CW'(1) && cnt <= CW'(OCT_W)));
endmodule

// File: rtl/codir_rx.sv
module codir_rx #(
    parameter int OCT_W       = 8,
    parameter int MISS_LIM    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_pcm,
    input  logic rst_n,
    input  logic rclk,
    input  logic line_p_n,
    input  logic line_m_n,
    input  logic slot_a,
    input  logic slot_b,
    input  logic slot_pick,
    input  logic miss_blank_n,
    input  logic force_ones,
    output logic pcm_out,
    output logic slip_repeat,
    output logic slip_drop,
    output logic octet_alarm
);
    logic [OCT_W:0] bank0, bank1;
    logic           wr_tog, tog_s, slot_sel;

    assign slot_sel = slot_pick ? slot_a : slot_b;

    codir_line_rx #(.OCT_W(OCT_W), .MISS_LIM(MISS_LIM)) u_line (
        .rclk(rclk), .rst_n(rst_n), .line_p_n(line_p_n), .line_m_n(line_m_n),
        .bank0(bank0), .bank1(bank1), .wr_tog(wr_tog), .alarm(octet_alarm)
    );

    codir_tog_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_pcm), .rst_n(rst_n), .d(wr_tog), .q(tog_s)
    );

    codir_pcm_tx #(.OCT_W(OCT_W)) u_pcm (
        .clk(clk_pcm), .rst_n(rst_n), .slot(slot_sel), .force_ones(force_ones),
        .miss_blank_n(miss_blank_n), .tog_s(tog_s), .bank0(bank0), .bank1(bank1),
        .pcm_q(pcm_out), .rep_q(slip_repeat), .del_q(slip_drop)
    );
endmodule

// File: tb/sim_codir_rx.sv
module sim_codir_rx;
    logic clk = 1'b0, rst_n = 1'b0, rclk = 1'b0;
    logic lp_n = 1'b1, lm_n = 1'b1, slot_a = 1'b0, slot_b = 1'b0, slot_pick = 1'b1;
    logic miss_blank_n = 1'b1, force_ones = 1'b0;
    logic pcm_out, slip_repeat, slip_drop, octet_alarm;
    int   tests = 0, fails = 0;
    bit   done = 0;
    bit   lastp = 1'b0;
    logic [8:0]  pend[$];
    logic [8:0]  last_word = 9'h0FF;
    logic [7:0]  exp_d[$];
    bit          exp_r[$], exp_x[$];
    string       exp_t[$];
    wire         eff = slot_pick ? slot_a : slot_b;

    always #2 clk = ~clk;

    codir_rx u0 (
        .clk_pcm(clk), .rst_n(rst_n), .rclk(rclk), .line_p_n(lp_n), .line_m_n(lm_n),
        .slot_a(slot_a), .slot_b(slot_b), .slot_pick(slot_pick),
        .miss_blank_n(miss_blank_n), .force_ones(force_ones),
        .pcm_out(pcm_out), .slip_repeat(slip_repeat), .slip_drop(slip_drop),
        .octet_alarm(octet_alarm)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick(input logic p, input logic m);
        lp_n = p; lm_n = m;
        #5 rclk = 1'b1;
        #5 rclk = 1'b0;
    endtask

    // R2: UI0 marks the block polarity rail, UI1 is a mark for 1 and a space for 0
    task automatic send_bit(input bit b, input bit viol);
        bit p;
        p = viol ? lastp : ~lastp;
        lastp = p;
        tick(~p, p);
        if (b) tick(~p, p);
        else   tick(1'b1, 1'b1);
    endtask

    task automatic send_octet(input logic [7:0] d, input bit viol, input bit store);
        for (int i = 0; i < 8; i++) send_bit(d[i], (i == 7) && viol);
        if (store) pend.push_back({~viol, d});
    endtask

    task automatic queue_burst(input string tag);
        int n;
        logic [8:0] w;
        n = pend.size();
        w = (n == 0) ? last_word : pend[n-1];
        last_word = w;
        pend.delete();
        exp_d.push_back((force_ones || (!miss_blank_n && w[8])) ? 8'hFF : w[7:0]);
        exp_r.push_back(n == 0);
        exp_x.push_back(n >= 2);
        exp_t.push_back(tag);
    endtask

    task automatic fire(input string tag);
        repeat (10) @(posedge clk);
        queue_burst(tag);
        @(negedge clk);
        if (slot_pick) slot_a = 1'b1; else slot_b = 1'b1;
        repeat (8) @(posedge clk);
        @(negedge clk);
        slot_a = 1'b0; slot_b = 1'b0;
        repeat (6) @(posedge clk);
    endtask

    // monitor: collects every burst and compares against the scoreboard
    initial begin
        forever begin
            logic [7:0] got;
            bit r, x;
            string t;
            @(posedge eff);
            for (int k = 0; k < 8; k++) begin
                @(posedge clk); @(negedge clk);
                got[k] = pcm_out;
                if (k == 0) begin r = slip_repeat; x = slip_drop; end
            end
            @(posedge clk); @(negedge clk);
            chk(pcm_out == 1'b1, "R4 idle high after burst", pcm_out, 1);
            if (exp_d.size() == 0) begin
                chk(1'b0, "R4 unexpected burst", got, 0);
            end else begin
                t = exp_t.pop_front();
                chk(got == exp_d[0], {t, " burst data"}, got, exp_d[0]);
                chk(r == exp_r[0], {t, " repeat flag (R11)"}, r, exp_r[0]);
                chk(x == exp_x[0], {t, " drop flag (R12)"}, x, exp_x[0]);
                void'(exp_d.pop_front()); void'(exp_r.pop_front()); void'(exp_x.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(pcm_out == 1'b1, "R1 pcm_out in reset", pcm_out, 1);
        chk(slip_repeat == 1'b0 && slip_drop == 1'b0, "R1 flags in reset", {slip_repeat, slip_drop}, 0);
        chk(octet_alarm == 1'b0, "R1 alarm in reset", octet_alarm, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R3 hunt: first violation locks but stores nothing -> replay of reset word 8'hFF
        send_octet(8'hA5, 1'b1, 1'b0);
        fire("R3 hunt");
        // R2 R3 normal octets
        send_octet(8'h3C, 1'b1, 1'b1); fire("R2 3C");
        send_octet(8'h81, 1'b1, 1'b1); fire("R3 81");
        send_octet(8'h5A, 1'b1, 1'b1); fire("R2 5A");
        // R11 repeat
        fire("R11 repeat");
        // R12 drop
        send_octet(8'h12, 1'b1, 1'b1);
        send_octet(8'h34, 1'b1, 1'b1);
        fire("R12 drop");
        // R5 unselected slot ignored
        send_octet(8'h77, 1'b1, 1'b1);
        repeat (10) @(posedge clk);
        @(negedge clk);
        slot_b = 1'b1;
        for (int k = 0; k < 9; k++) begin
            @(posedge clk); @(negedge clk);
            chk(pcm_out == 1'b1, "R5 unselected slot_b", pcm_out, 1);
        end
        slot_b = 1'b0;
        slot_pick = 1'b0;
        fire("R5 slot_b selected");
        slot_pick = 1'b1;
        // R8 forced ones
        send_octet(8'hC3, 1'b1, 1'b1);
        force_ones = 1'b1;
        fire("R8 force_ones");
        force_ones = 1'b0;
        // R6 flywheel
        send_octet(8'h96, 1'b0, 1'b1);
        fire("R6 flywheel");
        // R7 blanking of missing violation
        send_octet(8'h69, 1'b0, 1'b1);
        miss_blank_n = 1'b0;
        fire("R7 miss blank");
        miss_blank_n = 1'b1;
        // R9 alarm after eight missing
        send_octet(8'h00, 1'b1, 1'b1);
        chk(octet_alarm == 1'b0, "R10 alarm low after violation", octet_alarm, 0);
        for (int i = 0; i < 7; i++) send_octet(8'(i + 1), 1'b0, 1'b1);
        chk(octet_alarm == 1'b0, "R9 alarm after 7 missing", octet_alarm, 0);
        send_octet(8'hF0, 1'b0, 1'b1);
        chk(octet_alarm == 1'b1, "R9 alarm after 8 missing", octet_alarm, 1);
        fire("R9 drop of backlog");
        // R10 clear on expected violation
        send_octet(8'hE7, 1'b1, 1'b1);
        chk(octet_alarm == 1'b0, "R10 alarm cleared", octet_alarm, 0);
        fire("R10 E7");
        // R13 misplaced violation realigns, partial discarded
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b1);
        send_octet(8'h4B, 1'b1, 1'b1);
        fire("R13 realign");

        repeat (30) @(posedge clk);
        chk(exp_d.size() == 0, "R4 all bursts seen", exp_d.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule